// File: doc/BRIEF.md
# Supervisory Reset Generator

This block turns a digitised supply-good flag, an active-low manual-reset button input and a battery-backup flag into one active-low system reset. Reset is held asserted while any asserting condition is present: supply not good, manual reset low, or backup mode active. Once every condition has cleared, reset stays asserted for a further stretch of `HOLD_CYCLES` clock cycles. If a condition comes back during that stretch, the stretch counter starts again from zero.

A manual-reset press held low for at least `QUAL_CYCLES` consecutive synchronised cycles counts as qualified. On qualification the block issues a one-cycle clear strobe, which the neighbouring watchdog and chip-enable logic use to zero their counters. It also raises a force level, which drives those neighbours' fault outputs and chip-enable output to their inactive-high state. The force level stays up for as long as the button is held.

A shorter press still asserts and stretches reset, but it issues neither the strobe nor the force level. A one-cycle release strobe marks the cycle in which reset deasserts. All three inputs pass through a two-flop synchroniser. Every delay is a parameter counted in clock cycles.

Top module: `sup_reset_gen`

## Requirements
- R1: While `supply_ok_i` is low, `sys_rst_n_o` is low. It goes low on the third rising edge after `supply_ok_i` falls: two synchroniser stages plus one output register.
- R2: While `man_rst_n_i` is low, `sys_rst_n_o` is low, with the same three-edge latency. This holds for a press of any length, qualified or not.
- R3: After the last asserting condition clears, `sys_rst_n_o` rises on rising edge 2 + `HOLD_CYCLES`, counted from the input change.
- R4: A manual press lasting at least `QUAL_CYCLES` synchronised cycles raises `wd_clear_o` for exactly one cycle and raises `ctl_force_o` in that same cycle, on edge 2 + `QUAL_CYCLES` after the fall. `ctl_force_o` drops on the third edge after `man_rst_n_i` returns high. While `ctl_force_o` is high, `sys_rst_n_o` is low.
- R5: A manual press shorter than `QUAL_CYCLES` cycles leaves `wd_clear_o` and `ctl_force_o` low throughout. It still asserts and stretches reset.
- R6: While `backup_i` is high, `sys_rst_n_o` is low, whatever the value of `supply_ok_i`. The latency is the same three edges.
- R7: If an asserting condition returns before the stretch completes, the stretch restarts from zero. Release then follows R3, counted from the final clearing.
- R8: While the block's own `rst_n` is low, `sys_rst_n_o`, `rst_release_o`, `wd_clear_o` and `ctl_force_o` are all low. After `rst_n` rises with all conditions clear, reset releases per R3, counted from the `rst_n` rise.
- R9: `rst_release_o` is high for exactly the one cycle in which `sys_rst_n_o` first reads high after being low, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block's own asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply-good flag from the external comparator, high = good |
| man_rst_n_i | input | 1 | Manual reset request, active low |
| backup_i | input | 1 | Battery-backup mode flag, high = on battery |
| sys_rst_n_o | output | 1 | System reset, active low |
| rst_release_o | output | 1 | One-cycle strobe on the cycle reset deasserts |
| wd_clear_o | output | 1 | One-cycle counter-clear strobe for neighbour logic |
| ctl_force_o | output | 1 | Level forcing neighbour fault and chip-enable outputs high |

## Verification
Each result has a fixed latency from its input change:
- Assertion of reset: the third rising edge.
- Release of reset: edge 2 + `HOLD_CYCLES`.
- Clear strobe and rise of the force level: edge 2 + `QUAL_CYCLES` after the press.
- Fall of the force level: the third edge after the button is let go.

The driver records the cycle number at which it changes an input and queues the expected output value for exactly those cycles. It also queues the expected value for the cycle just before, so that an early change is caught as well as a late one. The monitor samples at the falling edge and retires each expectation only in its own cycle.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

  // Bundle of the three asserting inputs, carried through the synchroniser.
  typedef struct packed {
    logic backup;
    logic man_n;
    logic supply_ok;
  } sup_cond_t;

  localparam int COND_W = $bits(sup_cond_t);

  // Values taken by the synchroniser during the block's own reset: the
  // supply counts as not good, so reset is requested until it is seen good.
  localparam sup_cond_t COND_SAFE = '{backup: 1'b0, man_n: 1'b1, supply_ok: 1'b0};

endpackage

// File: rtl/sup_rst_sync.sv
module sup_rst_sync #(
  parameter int               W       = 3,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int g = 0; g < STAGES; g++) stg[g] <= RST_VAL;
        end else begin
          for (int g = STAGES - 1; g > 0; g--) stg[g] <= stg[g-1];
          stg[0] <= d_i;
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/sup_mr_qual.sv
module sup_mr_qual #(
  parameter int QUAL_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic man_n_s,
  output logic clear_o,
  output logic force_o
);

  localparam int            CW   = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] run_cnt;
  logic          qual_q;
  logic          clear_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      qual_q  <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      clear_q <= 1'b0;
      if (man_n_s) begin
        run_cnt <= '0;
        qual_q  <= 1'b0;
      end else if (!qual_q) begin
        if (run_cnt == LAST) begin
          qual_q  <= 1'b1;
          clear_q <= 1'b1;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end
    end
  end

  assign clear_o = clear_q;
  assign force_o = qual_q;

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
  parameter int HOLD_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_i,
  output logic rst_act_o,
  output logic release_o
);

  localparam int            CW   = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] hold_cnt;
  logic          act_q;
  logic          rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      act_q    <= 1'b1;
      rel_q    <= 1'b0;
    end else begin
      rel_q <= 1'b0;
      if (hold_req_i) begin
        act_q    <= 1'b1;
        hold_cnt <= '0;
      end else if (act_q) begin
        if (hold_cnt == LAST) begin
          act_q    <= 1'b0;
          hold_cnt <= '0;
          rel_q    <= 1'b1;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end
    end
  end

  assign rst_act_o = act_q;
  assign release_o = rel_q;

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
  import sup_rst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 8,
  parameter int HOLD_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic man_rst_n_i,
  input  logic backup_i,
  output logic sys_rst_n_o,
  output logic rst_release_o,
  output logic wd_clear_o,
  output logic ctl_force_o
);

  sup_cond_t raw_cond;
  sup_cond_t syn_cond;
  logic      hold_req;
  logic      rst_act;

  assign raw_cond = '{backup: backup_i, man_n: man_rst_n_i, supply_ok: supply_ok_i};

  sup_rst_sync #(
    .W       (COND_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (COND_SAFE)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_cond),
    .q_o   (syn_cond)
  );

  // Any one condition requests reset; backup mode implies reset on its own.
  assign hold_req = ~syn_cond.supply_ok | ~syn_cond.man_n | syn_cond.backup;

  sup_mr_qual #(
    .QUAL_CYCLES (QUAL_CYCLES)
  ) qual_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .man_n_s (syn_cond.man_n),
    .clear_o (wd_clear_o),
    .force_o (ctl_force_o)
  );

  sup_hold_timer #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) hold_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_req_i (hold_req),
    .rst_act_o  (rst_act),
    .release_o  (rst_release_o)
  );

  assign sys_rst_n_o = ~rst_act;

endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
  parameter int HOLD = 64
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok_i,
  input logic man_rst_n_i,
  input logic backup_i,
  input logic sys_rst_n_o,
  input logic rst_release_o,
  input logic wd_clear_o,
  input logic ctl_force_o
);

  int low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_run <= 0;
    else if (!sys_rst_n_o)     low_run <= (low_run < 32'h3fff_ffff) ? low_run + 1 : low_run;
    else                       low_run <= 0;
  end

  assert_supply_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok_i && $past(!supply_ok_i)) |-> ##2 !sys_rst_n_o);

  assert_man_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_rst_n_i && $past(!man_rst_n_i)) |-> ##2 !sys_rst_n_o);

  assert_min_stretch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n_o) |-> (low_run >= HOLD));

  assert_force_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_force_o |-> !sys_rst_n_o);

  assert_clear_on_force_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_clear_o |-> (ctl_force_o && !$past(ctl_force_o)));

  assert_backup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (backup_i && $past(backup_i)) |-> ##2 !sys_rst_n_o);

  assert_release_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_release_o |-> (sys_rst_n_o && !$past(sys_rst_n_o)));

  assert_release_seen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n_o) |-> rst_release_o);

endmodule

bind sup_reset_gen sup_reset_gen_chk #(.HOLD(HOLD_CYCLES)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .supply_ok_i   (supply_ok_i),
  .man_rst_n_i   (man_rst_n_i),
  .backup_i      (backup_i),
  .sys_rst_n_o   (sys_rst_n_o),
  .rst_release_o (rst_release_o),
  .wd_clear_o    (wd_clear_o),
  .ctl_force_o   (ctl_force_o)
);

// File: tb/sup_reset_gen_tb_top.sv
`timescale 1ns/1ps
module sup_reset_gen_tb_top;

  localparam int QUAL = 8;
  localparam int HOLD = 64;
  localparam int S_RST = 0, S_REL = 1, S_CLR = 2, S_FRC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1;
  logic man_n = 1'b1;
  logic backup = 1'b0;
  logic sys_rst_n, rel, clr, frc;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    q_cyc[$];
  int    q_sig[$];
  bit    q_val[$];
  string q_req[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sup_reset_gen #(.SYNC_STAGES(2), .QUAL_CYCLES(QUAL), .HOLD_CYCLES(HOLD)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok_i   (supply_ok),
    .man_rst_n_i   (man_n),
    .backup_i      (backup),
    .sys_rst_n_o   (sys_rst_n),
    .rst_release_o (rel),
    .wd_clear_o    (clr),
    .ctl_force_o   (frc)
  );

  task automatic expect_at(input int c, input int sig, input bit val, input string req);
    q_cyc.push_back(c);
    q_sig.push_back(sig);
    q_val.push_back(val);
    q_req.push_back(req);
  endtask

  // Monitor: retire every expectation due in the current cycle.
  always @(negedge clk) begin
    for (int i = q_cyc.size() - 1; i >= 0; i--) begin
      if (q_cyc[i] == cyc) begin
        logic act;
        case (q_sig[i])
          S_RST:   act = sys_rst_n;
          S_REL:   act = rel;
          S_CLR:   act = clr;
          default: act = frc;
        endcase
        checks++;
        if (act !== q_val[i]) begin
          errors++;
          $display("FAIL %s cycle %0d signal %0d actual=%b expected=%b",
                   q_req[i], cyc, q_sig[i], act, q_val[i]);
        end
        q_cyc.delete(i); q_sig.delete(i); q_val.delete(i); q_req.delete(i);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q_cyc.size() > 0) @(negedge clk);
    step(3);
  endtask

  // Queue the release edge for conditions cleared at cycle m.
  task automatic expect_release(input int m, input string req);
    expect_at(m + 1 + HOLD, S_RST, 1'b0, req);
    expect_at(m + 2 + HOLD, S_RST, 1'b1, req);
    expect_at(m + 1 + HOLD, S_REL, 1'b0, "R9");
    expect_at(m + 2 + HOLD, S_REL, 1'b1, "R9");
    expect_at(m + 3 + HOLD, S_REL, 1'b0, "R9");
  endtask

  initial begin
    int n, m, m2;
    step(3);
    // R8: state while the block's own reset is held.
    n = cyc;
    expect_at(n + 1, S_RST, 1'b0, "R8");
    expect_at(n + 1, S_REL, 1'b0, "R8");
    expect_at(n + 1, S_CLR, 1'b0, "R8");
    expect_at(n + 1, S_FRC, 1'b0, "R8");
    step(2);
    n = cyc; rst_n = 1'b1;
    expect_release(n, "R8");
    drain();

    // R1 / R3: supply dip.
    n = cyc; supply_ok = 1'b0;
    expect_at(n + 2, S_RST, 1'b1, "R1");
    expect_at(n + 3, S_RST, 1'b0, "R1");
    step(5);
    m = cyc; supply_ok = 1'b1;
    expect_release(m, "R3");
    drain();

    // R2 / R4: long qualified press.
    n = cyc; man_n = 1'b0;
    expect_at(n + 3, S_RST, 1'b0, "R2");
    expect_at(n + 1 + QUAL, S_CLR, 1'b0, "R4");
    expect_at(n + 2 + QUAL, S_CLR, 1'b1, "R4");
    expect_at(n + 3 + QUAL, S_CLR, 1'b0, "R4");
    expect_at(n + 1 + QUAL, S_FRC, 1'b0, "R4");
    expect_at(n + 2 + QUAL, S_FRC, 1'b1, "R4");
    step(QUAL + 20);
    m = cyc; man_n = 1'b1;
    expect_at(m + 1, S_RST, 1'b0, "R2");
    expect_at(m + 2, S_FRC, 1'b1, "R4");
    expect_at(m + 3, S_FRC, 1'b0, "R4");
    expect_release(m, "R2");
    drain();

    // R5: press one cycle short of qualification.
    n = cyc; man_n = 1'b0;
    expect_at(n + 3, S_RST, 1'b0, "R5");
    for (int k = 2; k <= QUAL + 4; k++) begin
      expect_at(n + k, S_CLR, 1'b0, "R5");
      expect_at(n + k, S_FRC, 1'b0, "R5");
    end
    step(QUAL - 1);
    m = cyc; man_n = 1'b1;
    expect_release(m, "R5");
    drain();

    // R4 boundary: press of exactly the qualification length.
    n = cyc; man_n = 1'b0;
    expect_at(n + 2 + QUAL, S_CLR, 1'b1, "R4");
    expect_at(n + 2 + QUAL, S_FRC, 1'b1, "R4");
    expect_at(n + 3 + QUAL, S_FRC, 1'b0, "R4");
    step(QUAL);
    m = cyc; man_n = 1'b1;
    expect_release(m, "R4");
    drain();

    // R6: backup mode with the supply flag still good.
    n = cyc; backup = 1'b1;
    expect_at(n + 2, S_RST, 1'b1, "R6");
    expect_at(n + 3, S_RST, 1'b0, "R6");
    step(10);
    m = cyc; backup = 1'b0;
    expect_release(m, "R6");
    drain();

    // R7: condition returns mid-stretch.
    supply_ok = 1'b0;
    step(4);
    m = cyc; supply_ok = 1'b1;
    expect_at(m + 2 + HOLD, S_RST, 1'b0, "R7");
    step(HOLD / 2);
    supply_ok = 1'b0;
    step(3);
    m2 = cyc; supply_ok = 1'b1;
    expect_release(m2, "R7");
    drain();

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d actual=running expected=finished", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule